// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

This block guards a superscalar dispatch stage against a costly replay: a load that reads bytes written by a store dispatched earlier in the same dispatch group. As each store commits into the group, the block records the store's memory footprint. A footprint is a base identifier, a signed byte offset and a byte size. For each load query it reports, in the same cycle, whether the load's footprint overlaps any recorded store. The dispatch logic turns that flag into a no-op insertion.

Recording is capacity-limited, and all recorded footprints are dropped at each group boundary. Footprints are compared only when their base identifiers are equal. Between two footprints with the same base, the block checks for overlapping byte ranges, not only for identical addresses. The offset sums carry one extra bit so that ranges near the top of the signed offset range compare correctly.

Top module: `grp_overlap_guard`

## Requirements
- R1: After reset no footprint is held, and no load query reports a conflict.
- R2: A load whose base and offset both equal those of a held store conflicts, even when the load size is zero.
- R3: With equal bases and the store offset below the load offset, a conflict exists exactly when store offset + store size is greater than the load offset. A store that ends where the load starts does not conflict.
- R4: With equal bases and the store offset at or above the load offset, a conflict exists exactly when load offset + load size is greater than the store offset.
- R5: A held store whose base differs from the load's base never produces a conflict.
- R6: conflict_o is 0 unless ld_query_i and ld_info_vld_i are both 1.
- R7: A store committed with st_info_vld_i = 0 is not recorded.
- R8: At most DEPTH (default 4) footprints are held. A store committed while DEPTH are held is not recorded, and the held ones stay unchanged.
- R9: grp_end_i = 1 at a rising clock edge drops every held footprint. A store committed in the same cycle is not recorded.
- R10: conflict_o is combinational in the load query. A store committed at a clock edge is visible to queries from just after that edge, and not before it.
- R11: Offsets are 32-bit two's complement and sizes are 8-bit unsigned. Range ends are formed without wrap-around, so footprints that cross the sign boundary or lie at negative offsets compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grp_end_i | input | 1 | Dispatch group ends: drop all held footprints |
| st_commit_i | input | 1 | A store commits into the current group this cycle |
| st_info_vld_i | input | 1 | The committing store carries memory-operand information |
| st_base_i | input | 16 | Base identifier of the committing store |
| st_ofs_i | input | 32 | Signed byte offset of the committing store |
| st_size_i | input | 8 | Byte size of the committing store |
| ld_query_i | input | 1 | A load is being checked this cycle |
| ld_info_vld_i | input | 1 | The queried load carries memory-operand information |
| ld_base_i | input | 16 | Base identifier of the queried load |
| ld_ofs_i | input | 32 | Signed byte offset of the queried load |
| ld_size_i | input | 8 | Byte size of the queried load |
| conflict_o | output | 1 | Queried load overlaps a held store |

## Verification
Two pairs of functions can fall in the same cycle. A store commit can meet a group end, and a store commit can meet a load query against the store being committed. The bench drives a commit together with grp_end_i and then queries that store's footprint. Any conflict here shows the clear lost to the record. The bench also holds a load query on the same footprint across the commit edge. The flag must read 0 before the edge and 1 after it.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int BASE_W = 16;
  localparam int OFS_W  = 32;
  localparam int SIZE_W = 8;
  localparam int EXT_W  = OFS_W + 1;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [OFS_W-1:0]  ofs;
    logic [SIZE_W-1:0] size;
  } footprint_t;
endpackage

// File: rtl/ovl_rst_sync.sv
module ovl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ovl_fp_store.sv
module ovl_fp_store
  import ovl_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_req_i,
  input  footprint_t       wr_fp_i,
  output logic [DEPTH-1:0] ent_vld_o,
  output footprint_t       ent_fp_o [DEPTH],
  output logic [CNT_W-1:0] held_cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] wr_sel;
  logic             wr_en;
  footprint_t       fp_q [DEPTH];

  // next state: clear has priority, full store drops the request
  always_comb begin
    cnt_d = cnt_q;
    vld_d = vld_q;
    wr_en = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
      vld_d = '0;
    end else if (wr_req_i && (cnt_q < CNT_W'(DEPTH))) begin
      wr_en = 1'b1;
      cnt_d = cnt_q + 1'b1;
      vld_d = vld_q | wr_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign wr_sel[i] = (cnt_q == CNT_W'(i));

    always_ff @(posedge clk) begin
      if (wr_en && wr_sel[i]) fp_q[i] <= wr_fp_i;
    end

    assign ent_fp_o[i] = fp_q[i];
  end

  assign ent_vld_o  = vld_q;
  assign held_cnt_o = cnt_q;
endmodule

// File: rtl/ovl_range_cmp.sv
module ovl_range_cmp
  import ovl_pkg::*;
(
  input  logic       ent_vld_i,
  input  footprint_t st_fp_i,
  input  footprint_t ld_fp_i,
  output logic       hit_o
);
  logic signed [EXT_W-1:0] st_lo, st_hi, ld_lo, ld_hi;
  logic same_base, exact, ovl;

  always_comb begin
    st_lo = $signed({st_fp_i.ofs[OFS_W-1], st_fp_i.ofs});
    ld_lo = $signed({ld_fp_i.ofs[OFS_W-1], ld_fp_i.ofs});
    st_hi = st_lo + $signed({{(EXT_W-SIZE_W){1'b0}}, st_fp_i.size});
    ld_hi = ld_lo + $signed({{(EXT_W-SIZE_W){1'b0}}, ld_fp_i.size});
    same_base = (st_fp_i.base == ld_fp_i.base);
    exact     = same_base && (st_fp_i.ofs == ld_fp_i.ofs);
    if (st_lo < ld_lo) ovl = (st_hi > ld_lo);
    else               ovl = (ld_hi > st_lo);
    hit_o = ent_vld_i && (exact || (same_base && ovl));
  end
endmodule

// File: rtl/grp_overlap_guard.sv
module grp_overlap_guard
  import ovl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_end_i,
  input  logic              st_commit_i,
  input  logic              st_info_vld_i,
  input  logic [BASE_W-1:0] st_base_i,
  input  logic [OFS_W-1:0]  st_ofs_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              ld_query_i,
  input  logic              ld_info_vld_i,
  input  logic [BASE_W-1:0] ld_base_i,
  input  logic [OFS_W-1:0]  ld_ofs_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output logic              conflict_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rst_sync_n;
  logic [DEPTH-1:0] ent_vld;
  logic [DEPTH-1:0] ent_hit;
  logic [CNT_W-1:0] held_cnt;
  footprint_t       ent_fp [DEPTH];
  footprint_t       st_fp, ld_fp;
  logic             wr_req, query_en;

  ovl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign st_fp    = '{base: st_base_i, ofs: st_ofs_i, size: st_size_i};
  assign ld_fp    = '{base: ld_base_i, ofs: ld_ofs_i, size: ld_size_i};
  assign wr_req   = st_commit_i && st_info_vld_i;
  assign query_en = ld_query_i && ld_info_vld_i;

  ovl_fp_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (grp_end_i),
    .wr_req_i   (wr_req),
    .wr_fp_i    (st_fp),
    .ent_vld_o  (ent_vld),
    .ent_fp_o   (ent_fp),
    .held_cnt_o (held_cnt)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    ovl_range_cmp u_cmp (
      .ent_vld_i (ent_vld[i]),
      .st_fp_i   (ent_fp[i]),
      .ld_fp_i   (ld_fp),
      .hit_o     (ent_hit[i])
    );
  end

  assign conflict_o = query_en && (|ent_hit);
endmodule

// File: rtl/ovl_guard_chk.sv
module ovl_guard_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             grp_end_i,
  input logic             st_commit_i,
  input logic             st_info_vld_i,
  input logic             ld_query_i,
  input logic             ld_info_vld_i,
  input logic             conflict_o,
  input logic [CNT_W-1:0] held_cnt
);
  a_r6_query_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ld_query_i && ld_info_vld_i) |-> !conflict_o);

  a_r1_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (held_cnt == '0) |-> !conflict_o);

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grp_end_i |=> (held_cnt == '0));

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grp_end_i |=> !conflict_o);

  a_r10_record: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_commit_i && st_info_vld_i && !grp_end_i && (held_cnt < CNT_W'(DEPTH)))
    |=> (held_cnt == CNT_W'($past(held_cnt) + 1'b1)));

  a_r7_no_info: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_commit_i && !st_info_vld_i && !grp_end_i) |=> $stable(held_cnt));

  a_r8_cap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((held_cnt == CNT_W'(DEPTH)) && !grp_end_i) |=> (held_cnt == CNT_W'(DEPTH)));
endmodule

bind grp_overlap_guard ovl_guard_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .grp_end_i     (grp_end_i),
  .st_commit_i   (st_commit_i),
  .st_info_vld_i (st_info_vld_i),
  .ld_query_i    (ld_query_i),
  .ld_info_vld_i (ld_info_vld_i),
  .conflict_o    (conflict_o),
  .held_cnt      (held_cnt)
);

// File: tb/tb_grp_overlap_guard.sv
`timescale 1ns/1ps
module tb_grp_overlap_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        grp_end, st_commit, st_info, ld_query, ld_info;
  logic [15:0] st_base, ld_base;
  logic [31:0] st_ofs, ld_ofs;
  logic [7:0]  st_size, ld_size;
  logic        conflict;
  int          checks = 0;
  int          failures = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  grp_overlap_guard dut (
    .clk(clk), .rst_n(rst_n), .grp_end_i(grp_end),
    .st_commit_i(st_commit), .st_info_vld_i(st_info),
    .st_base_i(st_base), .st_ofs_i(st_ofs), .st_size_i(st_size),
    .ld_query_i(ld_query), .ld_info_vld_i(ld_info),
    .ld_base_i(ld_base), .ld_ofs_i(ld_ofs), .ld_size_i(ld_size),
    .conflict_o(conflict)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic store(input logic [15:0] b, input logic [31:0] o,
                       input logic [7:0] s, input logic info);
    @(negedge clk);
    st_commit = 1'b1; st_info = info; st_base = b; st_ofs = o; st_size = s;
    @(posedge clk); #1;
    st_commit = 1'b0;
  endtask

  task automatic query(input logic [15:0] b, input logic [31:0] o,
                       input logic [7:0] s, input logic exp, input string req);
    @(negedge clk);
    ld_query = 1'b1; ld_info = 1'b1; ld_base = b; ld_ofs = o; ld_size = s;
    #1;
    chk(req, conflict, exp);
    ld_query = 1'b0;
  endtask

  task automatic end_group();
    @(negedge clk);
    grp_end = 1'b1;
    @(posedge clk); #1;
    grp_end = 1'b0;
  endtask

  task automatic t_reset(); // R1
    query(16'd1, 32'd0, 8'd4, 1'b0, "R1 reset empty");
  endtask

  task automatic t_exact(); // R2
    end_group();
    store(16'd1, 32'd100, 8'd4, 1'b1);
    query(16'd1, 32'd100, 8'd0, 1'b1, "R2 exact size0");
    query(16'd1, 32'd100, 8'd4, 1'b1, "R2 exact size4");
  endtask

  task automatic t_below(); // R3
    end_group();
    store(16'd2, 32'd16, 8'd8, 1'b1);
    query(16'd2, 32'd20, 8'd1, 1'b1, "R3 inside");
    query(16'd2, 32'd23, 8'd1, 1'b1, "R3 last byte");
    query(16'd2, 32'd24, 8'd4, 1'b0, "R3 touching");
  endtask

  task automatic t_above(); // R4
    end_group();
    store(16'd3, 32'd40, 8'd4, 1'b1);
    query(16'd3, 32'd36, 8'd4, 1'b0, "R4 touching");
    query(16'd3, 32'd37, 8'd4, 1'b1, "R4 overlap");
    query(16'd3, 32'd30, 8'd2, 1'b0, "R4 disjoint");
  endtask

  task automatic t_base(); // R5
    end_group();
    store(16'd4, 32'd0, 8'd16, 1'b1);
    query(16'd5, 32'd0, 8'd16, 1'b0, "R5 other base");
    query(16'd4, 32'd0, 8'd16, 1'b1, "R5 same base");
  endtask

  task automatic t_gate(); // R6
    @(negedge clk);
    ld_base = 16'd4; ld_ofs = 32'd0; ld_size = 8'd16;
    ld_query = 1'b0; ld_info = 1'b1; #1;
    chk("R6 no query", conflict, 1'b0);
    ld_query = 1'b1; ld_info = 1'b0; #1;
    chk("R6 no info", conflict, 1'b0);
    ld_query = 1'b0; ld_info = 1'b1;
  endtask

  task automatic t_noinfo(); // R7
    end_group();
    store(16'd6, 32'd0, 8'd8, 1'b0);
    query(16'd6, 32'd0, 8'd8, 1'b0, "R7 not recorded");
  endtask

  task automatic t_cap(); // R8
    end_group();
    for (int i = 0; i < 4; i++) store(16'd7, 32'(i * 8), 8'd8, 1'b1);
    store(16'd7, 32'd64, 8'd8, 1'b1);
    query(16'd7, 32'd64, 8'd8, 1'b0, "R8 fifth dropped");
    query(16'd7, 32'd24, 8'd8, 1'b1, "R8 fourth held");
    query(16'd7, 32'd0,  8'd1, 1'b1, "R8 first held");
  endtask

  task automatic t_clear(); // R9
    end_group();
    query(16'd7, 32'd0, 8'd8, 1'b0, "R9 cleared");
    @(negedge clk);
    grp_end = 1'b1; st_commit = 1'b1; st_info = 1'b1;
    st_base = 16'd8; st_ofs = 32'd0; st_size = 8'd8;
    @(posedge clk); #1;
    grp_end = 1'b0; st_commit = 1'b0;
    query(16'd8, 32'd0, 8'd8, 1'b0, "R9 clear beats commit");
  endtask

  task automatic t_timing(); // R10
    end_group();
    @(negedge clk);
    st_commit = 1'b1; st_info = 1'b1;
    st_base = 16'd9; st_ofs = 32'd0; st_size = 8'd4;
    ld_query = 1'b1; ld_info = 1'b1;
    ld_base = 16'd9; ld_ofs = 32'd0; ld_size = 8'd4;
    #1;
    chk("R10 before edge", conflict, 1'b0);
    @(posedge clk); #1;
    st_commit = 1'b0;
    chk("R10 after edge", conflict, 1'b1);
    ld_query = 1'b0;
  endtask

  task automatic t_signed(); // R11
    end_group();
    store(16'd10, 32'h7FFF_FFF0, 8'h20, 1'b1);
    query(16'd10, 32'h7FFF_FFF8, 8'd1, 1'b1, "R11 no wrap");
    end_group();
    store(16'd11, -32'sd8, 8'd8, 1'b1);
    query(16'd11, -32'sd4, 8'd2, 1'b1, "R11 negative overlap");
    query(16'd11, 32'd0,   8'd4, 1'b0, "R11 negative touching");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; grp_end = 1'b0; st_commit = 1'b0; st_info = 1'b0;
    ld_query = 1'b0; ld_info = 1'b0;
    st_base = '0; st_ofs = '0; st_size = '0;
    ld_base = '0; ld_ofs = '0; ld_size = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_exact();
    t_below();
    t_above();
    t_base();
    t_gate();
    t_noinfo();
    t_cap();
    t_clear();
    t_timing();
    t_signed();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule